// File: doc/BRIEF.md
# Audio Controller Control Port with Configuration Download RAM

This block is the host-facing control port of a multifunction audio controller. A byte-wide host bus chooses one of eight port registers by the low three address bits. Through an index/data pair the host reaches a small file of indirect control registers. Some of these registers are masked, some are read-only, and some exist only on newer silicon revisions, chosen by a parameter. A separate port offset gives access to a 384-byte configuration RAM. The host first sends a short command-and-address preamble and then streams bytes, and each access moves the RAM address on by one.

Two bits of configuration byte 3 enable the wavetable and FM functions. Bit 3 of that byte also shows up as bit 3 of indirect register 8. A global status register merges the interrupt flags of three sub-functions, which arrive here as inputs, with a context bit. The host flips the context bit to hand FM ownership between the two sound personalities. A write of indirect register 0 with bit 7 set sends a one-cycle reset pulse to the codec.

Top module: `audio_ctl_port`

## Requirements
- R1: After reset, indirect register 1 reads the `REV` parameter. Indirect register 2 reads 0x20 when `REV == REV_TOP` and 0x00 otherwise. All other indirect registers, the index, and the context bit read 0, and the download engine is idle.
- R2: Port offset 3 holds a 4-bit index that reads back as {4'b0, index}. Port offset 4 reads and writes the indirect register chosen by the index. Port offsets 0, 1, 2 and 6 read 0x00.
- R3: Indirect writes with an index of 9 to 15 are dropped, and those registers always read 0x00.
- R4: When `REV < REV_MIN`, writes to indirect registers 2 to 6 are dropped. On newer revisions they are stored.
- R5: Indirect writes are masked before storage: register 3 by 0xE0, register 4 by 0xF0, register 5 by 0xFE, register 8 by 0x0F. Registers 0, 1, 2, 6 and 7 store the full byte.
- R6: A write of indirect register 0 with bit 7 set drives `codec_rst` high for exactly the one cycle after the write edge. A write with bit 7 clear gives no pulse.
- R7: The download engine is entered through port offset 5 in this order: a command byte 0x5A (any other byte is ignored), then the low address byte, then the high address byte. After that it is in streaming mode. Any write to port offset 6 returns it to idle. Reads of offset 5 return 0x00 outside streaming mode.
- R8: In streaming mode, each write to offset 5 stores the byte at RAM index `address & 0x1FF` if the address lies in 0x4000 to 0x417F. Writes at any other address are dropped. Every write advances the address by one.
- R9: In streaming mode, each read of offset 5 returns the stored byte for an address in the window, or 0xFF outside it, and advances the address by one.
- R10: A read of port offset 7 returns the context bit in bit 7, the SB-personality interrupt in bit 5, the codec status flag in bit 4, and the MIDI interrupt in bit 3. Bits 6 and 2:0 read 0.
- R11: Any write to port offset 7 toggles the context bit. `fm_to_sb` is high exactly when the context bit is 0.
- R12: Bit 3 of RAM byte 3 drives `wt_enable` and is read as bit 3 of indirect register 8. Bit 7 of RAM byte 3 drives `fm_enable`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 3 | Port register select |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one access per cycle |
| rd_en | input | 1 | Read strobe; side effects occur at the clock edge |
| rdata | output | 8 | Read data for the selected register |
| irq_mpu | input | 1 | MIDI sub-function interrupt pending |
| irq_wss | input | 1 | Codec status flag |
| irq_sb | input | 1 | SB personality interrupt pending |
| codec_rst | output | 1 | One-cycle codec reset pulse |
| fm_to_sb | output | 1 | FM synthesis owned by SB personality |
| wt_enable | output | 1 | Wavetable enable from configuration byte |
| fm_enable | output | 1 | FM enable from configuration byte |

## Verification
The bench probes both edges of the RAM window with streamed accesses. A write at 0x4180 must not wrap onto byte 0, and a read that starts at 0x3FFF must give 0xFF and then move into the window. A design with a loose window check or no increment on reads would return the wrong bytes there. A second instance with an old revision shows that gated registers stay at zero, and the bench reads back the masked values so that a missing mask or a leaked byte-3 bit in register 8 is caught. It also checks that the codec reset pulse lasts exactly one cycle and appears only when bit 7 is set.

// File: rtl/audio_ctl_port.sv
module audio_ctl_port #(
  parameter logic [7:0] REV       = 8'h03,
  parameter logic [7:0] REV_MIN   = 8'h02,
  parameter logic [7:0] REV_TOP   = 8'h03,
  parameter int         RAM_BYTES = 384,
  parameter int         ADDR_W    = 16,
  parameter int         WIN_BASE  = 'h4000,
  parameter logic [7:0] DL_CMD    = 8'h5A
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] addr,
  input  logic [7:0] wdata,
  input  logic       wr_en,
  input  logic       rd_en,
  output logic [7:0] rdata,
  input  logic       irq_mpu,
  input  logic       irq_wss,
  input  logic       irq_sb,
  output logic       codec_rst,
  output logic       fm_to_sb,
  output logic       wt_enable,
  output logic       fm_enable
);
  localparam int IDX_W = $clog2(RAM_BYTES);
  localparam logic [ADDR_W:0] WIN_LO = (ADDR_W+1)'(WIN_BASE);
  localparam logic [ADDR_W:0] WIN_HI = (ADDR_W+1)'(WIN_BASE + RAM_BYTES);
  localparam logic [7:0] REG2_RST = (REV == REV_TOP) ? 8'h20 : 8'h00;
  localparam bit REV_OK = (REV >= REV_MIN);

  typedef enum logic [1:0] {DL_IDLE, DL_LO, DL_HI, DL_DATA} dl_state_t;

  dl_state_t         dl_st;
  logic [ADDR_W-1:0] ram_addr;
  logic [7:0]        ram [RAM_BYTES];
  logic [7:0]        ind [16];
  logic [3:0]        index;
  logic              ctx;

  wire wr_idx  = wr_en && addr == 3'd3;
  wire wr_ind  = wr_en && addr == 3'd4;
  wire acc_ram = addr == 3'd5 && dl_st == DL_DATA;
  wire in_win  = {1'b0, ram_addr} >= WIN_LO && {1'b0, ram_addr} < WIN_HI;
  wire [IDX_W-1:0] ram_idx = ram_addr[IDX_W-1:0];

  assign wt_enable = ram[3][3];
  assign fm_enable = ram[3][7];
  assign fm_to_sb  = ~ctx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      index <= '0;
      for (int i = 0; i < 16; i++) ind[i] <= 8'h00;
      ind[1] <= REV;
      ind[2] <= REG2_RST;
      codec_rst <= 1'b0;
    end else begin
      codec_rst <= 1'b0;
      if (wr_idx) index <= wdata[3:0];
      if (wr_ind) begin
        case (index)
          4'd0: begin
            ind[0] <= wdata;
            codec_rst <= wdata[7];
          end
          4'd1, 4'd7: ind[index] <= wdata;
          4'd2, 4'd6: if (REV_OK) ind[index] <= wdata;
          4'd3: if (REV_OK) ind[3] <= wdata & 8'hE0;
          4'd4: if (REV_OK) ind[4] <= wdata & 8'hF0;
          4'd5: if (REV_OK) ind[5] <= wdata & 8'hFE;
          4'd8: ind[8] <= wdata & 8'h0F;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctx <= 1'b0;
    end else if (wr_en && addr == 3'd7) begin
      ctx <= ~ctx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dl_st    <= DL_IDLE;
      ram_addr <= '0;
      for (int i = 0; i < RAM_BYTES; i++) ram[i] <= 8'h00;
    end else if (wr_en && addr == 3'd6) begin
      dl_st <= DL_IDLE;
    end else if (wr_en && addr == 3'd5) begin
      case (dl_st)
        DL_IDLE: if (wdata == DL_CMD) dl_st <= DL_LO;
        DL_LO: begin
          ram_addr[7:0] <= wdata;
          dl_st <= DL_HI;
        end
        DL_HI: begin
          ram_addr[ADDR_W-1:8] <= wdata[ADDR_W-9:0];
          dl_st <= DL_DATA;
        end
        default: begin
          if (in_win) ram[ram_idx] <= wdata;
          ram_addr <= ram_addr + 1'b1;
        end
      endcase
    end else if (rd_en && acc_ram) begin
      ram_addr <= ram_addr + 1'b1;
    end
  end

  logic [7:0] ind_rd, dl_rd;
  always_comb begin
    ind_rd = ind[index];
    if (index == 4'd8) ind_rd[3] = ram[3][3];
    dl_rd = 8'h00;
    if (dl_st == DL_DATA) dl_rd = in_win ? ram[ram_idx] : 8'hFF;
  end

  always_comb begin
    case (addr)
      3'd3:    rdata = {4'b0, index};
      3'd4:    rdata = ind_rd;
      3'd5:    rdata = dl_rd;
      3'd7:    rdata = {ctx, 1'b0, irq_sb, irq_wss, irq_mpu, 3'b000};
      default: rdata = 8'h00;
    endcase
  end

  AST_CODEC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    codec_rst |=> !codec_rst); // R6
  AST_CODEC_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(codec_rst) |-> $past(wr_ind && index == 4'd0 && wdata[7])); // R6
  AST_CTX_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd7) |=> (ctx != $past(ctx))); // R11
  AST_DL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_ram && (wr_en || rd_en) && !(wr_en && addr == 3'd6)) |=> (ram_addr == $past(ram_addr) + 1'b1)); // R8
  AST_STATUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 3'd7) |-> (rdata[6] == 1'b0 && rdata[2:0] == 3'b000)); // R10
  AST_HIGH_IDX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 3'd4 && index > 4'd8) |-> (rdata == 8'h00)); // R3
endmodule

// File: tb/tb_audio_ctl_port.sv
module tb_audio_ctl_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic irq_mpu = 1'b0, irq_wss = 1'b0, irq_sb = 1'b0;
  logic [7:0] rdata, rdata_old;
  logic codec_rst, fm_to_sb, wt_enable, fm_enable;
  logic codec_rst_o, fm_to_sb_o, wt_enable_o, fm_enable_o;
  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  audio_ctl_port dut (.clk, .rst_n, .addr, .wdata, .wr_en, .rd_en, .rdata,
    .irq_mpu, .irq_wss, .irq_sb, .codec_rst, .fm_to_sb, .wt_enable, .fm_enable);

  audio_ctl_port #(.REV(8'h01)) dut_old (.clk, .rst_n, .addr, .wdata, .wr_en, .rd_en,
    .rdata(rdata_old), .irq_mpu, .irq_wss, .irq_sb, .codec_rst(codec_rst_o),
    .fm_to_sb(fm_to_sb_o), .wt_enable(wt_enable_o), .fm_enable(fm_enable_o));

  // {op(1=read), port, wdata, expected, requirement}
  localparam int NV = 24;
  localparam logic [24:0] VEC [0:NV-1] = '{
    {1'b0, 3'd3, 8'h04, 8'h00, 5'd5}, {1'b0, 3'd4, 8'hFF, 8'h00, 5'd5},
    {1'b1, 3'd4, 8'h00, 8'hF0, 5'd5}, {1'b0, 3'd3, 8'h03, 8'h00, 5'd5},
    {1'b0, 3'd4, 8'hFF, 8'h00, 5'd5}, {1'b1, 3'd4, 8'h00, 8'hE0, 5'd5},
    {1'b0, 3'd3, 8'h05, 8'h00, 5'd5}, {1'b0, 3'd4, 8'hFF, 8'h00, 5'd5},
    {1'b1, 3'd4, 8'h00, 8'hFE, 5'd5}, {1'b0, 3'd3, 8'h08, 8'h00, 5'd5},
    {1'b0, 3'd4, 8'hFF, 8'h00, 5'd5}, {1'b1, 3'd4, 8'h00, 8'h07, 5'd12},
    {1'b0, 3'd3, 8'h0B, 8'h00, 5'd3}, {1'b1, 3'd3, 8'h00, 8'h0B, 5'd2},
    {1'b0, 3'd4, 8'hFF, 8'h00, 5'd3}, {1'b1, 3'd4, 8'h00, 8'h00, 5'd3},
    {1'b0, 3'd3, 8'h0F, 8'h00, 5'd3}, {1'b0, 3'd4, 8'h12, 8'h00, 5'd3},
    {1'b1, 3'd4, 8'h00, 8'h00, 5'd3}, {1'b0, 3'd3, 8'h06, 8'h00, 5'd4},
    {1'b0, 3'd4, 8'h3C, 8'h00, 5'd4}, {1'b1, 3'd4, 8'h00, 8'h3C, 5'd4},
    {1'b0, 3'd3, 8'hF2, 8'h00, 5'd2}, {1'b1, 3'd3, 8'h00, 8'h02, 5'd2}
  };

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [7:0] d, output logic [7:0] d_old);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1 d = rdata; d_old = rdata_old;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic dl_open(input logic [15:0] a);
    bus_wr(3'd5, 8'h5A);
    bus_wr(3'd5, a[7:0]);
    bus_wr(3'd5, a[15:8]);
  endtask

  task automatic finish_up();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: got hang expected completion");
      finish_up();
    end
  end

  initial begin
    logic [7:0] v, vo;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    bus_wr(3'd3, 8'h01); bus_rd(3'd4, v, vo);
    check("R1 rev", v, 8'h03); check("R1 rev old", vo, 8'h01);
    bus_wr(3'd3, 8'h02); bus_rd(3'd4, v, vo);
    check("R1 reg2 top", v, 8'h20); check("R1 reg2 old", vo, 8'h00);
    bus_rd(3'd7, v, vo); check("R1 status", v, 8'h00);
    check("R11 fm_to_sb reset", {7'b0, fm_to_sb}, 8'h01);
    bus_rd(3'd5, v, vo); check("R7 idle read", v, 8'h00);
    bus_rd(3'd0, v, vo); check("R2 offset0", v, 8'h00);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][24]) begin
        bus_rd(VEC[i][23:21], v, vo);
        nchk++;
        if (v !== VEC[i][12:5]) begin
          nfail++;
          $display("FAIL vector %0d R%0d: got %02h expected %02h", i, VEC[i][4:0], v, VEC[i][12:5]);
        end
      end else begin
        bus_wr(VEC[i][23:21], VEC[i][20:13]);
      end
    end

    // R4 revision gating on old instance
    bus_wr(3'd3, 8'h02); bus_wr(3'd4, 8'h55); bus_rd(3'd4, v, vo);
    check("R4 reg2 new", v, 8'h55); check("R4 reg2 old", vo, 8'h00);
    bus_wr(3'd3, 8'h03); bus_wr(3'd4, 8'hFF); bus_rd(3'd4, v, vo);
    check("R4 reg3 old", vo, 8'h00);
    bus_wr(3'd3, 8'h07); bus_wr(3'd4, 8'h66); bus_rd(3'd4, v, vo);
    check("R5 reg7 full", v, 8'h66); check("R4 reg7 old ungated", vo, 8'h66);

    // R6 codec reset pulse
    bus_wr(3'd3, 8'h00); bus_wr(3'd4, 8'h80);
    check("R6 pulse high", {7'b0, codec_rst}, 8'h01);
    @(negedge clk);
    check("R6 pulse one cycle", {7'b0, codec_rst}, 8'h00);
    bus_wr(3'd4, 8'h7F);
    check("R6 no pulse bit7 clear", {7'b0, codec_rst}, 8'h00);
    bus_rd(3'd4, v, vo); check("R5 reg0 full", v, 8'h7F);

    // R7/R8 download sequence
    bus_wr(3'd5, 8'h12); bus_rd(3'd5, v, vo); check("R7 bad cmd", v, 8'h00);
    dl_open(16'h4000);
    bus_wr(3'd5, 8'h11); bus_wr(3'd5, 8'h22); bus_wr(3'd5, 8'h33); bus_wr(3'd5, 8'h88);
    check("R12 wt_enable", {7'b0, wt_enable}, 8'h01);
    check("R12 fm_enable", {7'b0, fm_enable}, 8'h01);
    bus_wr(3'd6, 8'h00);
    bus_rd(3'd5, v, vo); check("R7 exit", v, 8'h00);
    bus_wr(3'd3, 8'h08); bus_rd(3'd4, v, vo); check("R12 reg8 bit3", v, 8'h0F);

    // R9 read back with increment
    dl_open(16'h4000);
    bus_rd(3'd5, v, vo); check("R9 byte0", v, 8'h11);
    bus_rd(3'd5, v, vo); check("R9 byte1", v, 8'h22);
    bus_rd(3'd5, v, vo); check("R9 byte2", v, 8'h33);
    bus_rd(3'd5, v, vo); check("R9 byte3", v, 8'h88);
    bus_wr(3'd6, 8'h00);

    // R8 upper window edge
    dl_open(16'h417F);
    bus_wr(3'd5, 8'h77); bus_wr(3'd5, 8'h99);
    bus_wr(3'd6, 8'h00);
    dl_open(16'h417E);
    bus_rd(3'd5, v, vo); check("R9 0x417E", v, 8'h00);
    bus_rd(3'd5, v, vo); check("R8 last byte", v, 8'h77);
    bus_rd(3'd5, v, vo); check("R9 past window", v, 8'hFF);
    bus_wr(3'd6, 8'h00);

    // R9 lower window edge
    dl_open(16'h3FFF);
    bus_wr(3'd5, 8'hAB);
    bus_wr(3'd6, 8'h00);
    dl_open(16'h3FFF);
    bus_rd(3'd5, v, vo); check("R9 below window", v, 8'hFF);
    bus_rd(3'd5, v, vo); check("R8 below write dropped", v, 8'h11);
    bus_wr(3'd6, 8'h00);

    // R10/R11 status
    irq_mpu = 1'b1; irq_sb = 1'b1;
    bus_rd(3'd7, v, vo); check("R10 mpu+sb", v, 8'h28);
    irq_mpu = 1'b0; irq_sb = 1'b0; irq_wss = 1'b1;
    bus_rd(3'd7, v, vo); check("R10 wss", v, 8'h10);
    irq_wss = 1'b0;
    bus_wr(3'd7, 8'h00);
    bus_rd(3'd7, v, vo); check("R11 ctx set", v, 8'h80);
    check("R11 fm_to_sb low", {7'b0, fm_to_sb}, 8'h00);
    bus_wr(3'd7, 8'h55);
    bus_rd(3'd7, v, vo); check("R11 ctx clear", v, 8'h00);
    check("R11 fm_to_sb high", {7'b0, fm_to_sb}, 8'h01);

    finish_up();
  end
endmodule